// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It runs two direction predictors side by side. The first is a pattern table of 2-bit saturating counters addressed by a 12-bit history of recent branch outcomes across the whole program. The second works in two levels: a table of per-branch 10-bit outcome histories, selected by instruction address, whose chosen history then addresses a table of 3-bit saturating counters. A third table of 2-bit counters, addressed by the same 12-bit history as the first predictor, learns which of the two predictors to trust and picks the final answer.

Lookup is combinational. The fetch stage presents a PC and receives the final prediction, both component predictions and the selector's choice. When the branch resolves, the update port is given the PC, the real outcome and the two component predictions saved from lookup. At the next clock edge the block trains both predictors, trains the selector only if the components disagreed, and shifts the outcome into both histories. A lookup made in the same cycle as an update sees the state from before that update.

Top module: `tourn_bpred`

## Requirements
- R1: After reset every 2-bit counter holds 1, every 3-bit counter holds 3 and every history is zero, so any lookup returns final, global and local predictions of not-taken and a selector choice of local (0).
- R2: `lk_taken` equals `lk_glob_pred` when the selector counter addressed by the global history is 2 or 3, and equals `lk_loc_pred` when it is 0 or 1; `lk_use_global` is 1 exactly in the first case.
- R3: The global prediction is taken when the 2-bit counter addressed by the 12-bit global history is 2 or more; on update that counter steps up on taken and down on not-taken, saturating at 0 and 3.
- R4: On each update the global history shifts left by one and the outcome enters bit 0 (1 = taken); without an update it does not change.
- R5: The local history entry is selected by PC bits [11:2]; on update the outcome shifts into bit 0 of that entry's 10-bit history.
- R6: The local prediction is taken when the 3-bit counter addressed by the selected 10-bit local history is 4 or more; on update that counter steps toward the outcome, saturating at 0 and 7.
- R7: The selector counter addressed by the global history changes only when the supplied global and local predictions differ; it then steps up if the global one matched the outcome and down otherwise, saturating at 0 and 3.
- R8: An update takes effect at the clock edge on which `up_valid` is sampled high; lookups before that edge see the older state.
- R9: PC bits outside [11:2] have no effect: two PCs that differ only in those bits get identical predictions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | 32 | PC of the branch being looked up |
| lk_taken | output | 1 | Final direction prediction |
| lk_glob_pred | output | 1 | Global predictor's direction |
| lk_loc_pred | output | 1 | Local predictor's direction |
| lk_use_global | output | 1 | Selector picked the global predictor |
| up_valid | input | 1 | Resolved branch update this cycle |
| up_pc | input | 32 | PC of the resolved branch |
| up_taken | input | 1 | Actual outcome (1 = taken) |
| up_glob_pred | input | 1 | Global prediction returned at lookup |
| up_loc_pred | input | 1 | Local prediction returned at lookup |

## Verification
A wrong counter, history bit or selector value stays hidden until a lookup lands on the corrupted entry, and then shows as a flipped component prediction or selector choice in that same cycle. A wrong global history shift disturbs every later lookup, so it shows at the first lookup after the faulty update; a wrong local history shift shows only on the next lookup of a branch that aliases the same PC[11:2] entry. Because training is hysteretic, a wrong step direction or saturation limit may need several repeated outcomes before an output flips, so the scenarios drive long one-sided runs and compare every lookup against an independent model.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
  // 2-bit saturating counter step
  function automatic logic [1:0] ctr2_step(input logic [1:0] c, input logic up);
    if (up) return (c == 2'd3) ? c : c + 2'd1;
    else    return (c == 2'd0) ? c : c - 2'd1;
  endfunction

  // 3-bit saturating counter step
  function automatic logic [2:0] ctr3_step(input logic [2:0] c, input logic up);
    if (up) return (c == 3'd7) ? c : c + 3'd1;
    else    return (c == 3'd0) ? c : c - 3'd1;
  endfunction

  localparam logic [1:0] CTR2_INIT = 2'd1;
  localparam logic [2:0] CTR3_INIT = 3'd3;
endpackage

// File: rtl/tbp_global_pht.sv
module tbp_global_pht #(
  parameter int HW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] rd_idx,
  output logic          rd_taken,
  input  logic          wr_en,
  input  logic [HW-1:0] wr_idx,
  input  logic          wr_taken
);
  import tbp_pkg::*;
  localparam int DEPTH = 1 << HW;

  logic [1:0] tab [DEPTH];
  logic [1:0] wr_old;

  assign rd_taken = tab[rd_idx][1];
  assign wr_old   = tab[wr_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tab[i] <= CTR2_INIT;
    end else if (wr_en) begin
      tab[wr_idx] <= ctr2_step(wr_old, wr_taken);
    end
  end

  // checker snapshot of the last write
  logic          chk_wr, chk_t;
  logic [HW-1:0] chk_idx;
  logic [1:0]    chk_old;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_wr <= 1'b0; chk_t <= 1'b0; chk_idx <= '0; chk_old <= '0;
    end else begin
      chk_wr <= wr_en; chk_t <= wr_taken; chk_idx <= wr_idx; chk_old <= wr_old;
    end
  end

  // R3
  glob_step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_wr && chk_t) |-> (tab[chk_idx] >= chk_old));
  // R3
  glob_step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_wr && !chk_t) |-> (tab[chk_idx] <= chk_old));
endmodule

// File: rtl/tbp_local.sv
module tbp_local #(
  parameter int PC_W = 32,
  parameter int IW   = 10,
  parameter int LW   = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_pred,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken
);
  import tbp_pkg::*;
  localparam int HDEPTH = 1 << IW;
  localparam int CDEPTH = 1 << LW;

  logic [LW-1:0] hist [HDEPTH];
  logic [2:0]    ctr  [CDEPTH];

  logic [IW-1:0] lk_idx, up_idx;
  logic [LW-1:0] up_hist;
  logic [2:0]    up_old;
  logic          unused_pc_bits;

  assign lk_idx  = lk_pc[IW+1:2];
  assign up_idx  = up_pc[IW+1:2];
  assign up_hist = hist[up_idx];
  assign up_old  = ctr[up_hist];
  assign lk_pred = ctr[hist[lk_idx]][2];
  assign unused_pc_bits = ^{lk_pc[PC_W-1:IW+2], lk_pc[1:0], up_pc[PC_W-1:IW+2], up_pc[1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < HDEPTH; i++) hist[i] <= '0;
      for (int j = 0; j < CDEPTH; j++) ctr[j]  <= CTR3_INIT;
    end else if (up_valid) begin
      ctr[up_hist] <= ctr3_step(up_old, up_taken);
      hist[up_idx] <= {up_hist[LW-2:0], up_taken};
    end
  end

  logic          chk_wr, chk_t;
  logic [IW-1:0] chk_hidx;
  logic [LW-1:0] chk_cidx;
  logic [2:0]    chk_old;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_wr <= 1'b0; chk_t <= 1'b0; chk_hidx <= '0; chk_cidx <= '0; chk_old <= '0;
    end else begin
      chk_wr <= up_valid; chk_t <= up_taken; chk_hidx <= up_idx;
      chk_cidx <= up_hist; chk_old <= up_old;
    end
  end

  // R5
  loc_hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_wr |-> (hist[chk_hidx][0] == chk_t));
  // R6
  loc_ctr_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_wr && chk_t) |-> (ctr[chk_cidx] >= chk_old));
  // R6
  loc_ctr_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_wr && !chk_t) |-> (ctr[chk_cidx] <= chk_old));
endmodule

// File: rtl/tbp_chooser.sv
module tbp_chooser #(
  parameter int HW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] rd_idx,
  output logic          use_global,
  input  logic          upd,
  input  logic [HW-1:0] wr_idx,
  input  logic          glob_pred,
  input  logic          loc_pred,
  input  logic          taken
);
  import tbp_pkg::*;
  localparam int DEPTH = 1 << HW;

  logic [1:0] tab [DEPTH];
  logic [1:0] wr_old;
  logic       disagree, glob_right, ch_wr_en;

  assign use_global = tab[rd_idx][1];
  assign wr_old     = tab[wr_idx];
  assign disagree   = glob_pred ^ loc_pred;
  assign glob_right = (glob_pred == taken);
  assign ch_wr_en   = upd && disagree;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tab[i] <= CTR2_INIT;
    end else if (ch_wr_en) begin
      tab[wr_idx] <= ctr2_step(wr_old, glob_right);
    end
  end

  logic          chk_agree, chk_move, chk_gr;
  logic [HW-1:0] chk_idx;
  logic [1:0]    chk_old;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_agree <= 1'b0; chk_move <= 1'b0; chk_gr <= 1'b0; chk_idx <= '0; chk_old <= '0;
    end else begin
      chk_agree <= upd && !disagree; chk_move <= ch_wr_en; chk_gr <= glob_right;
      chk_idx <= wr_idx; chk_old <= wr_old;
    end
  end

  // R7
  sel_hold_on_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_agree |-> (tab[chk_idx] == chk_old));
  // R7
  sel_toward_global_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_move && chk_gr) |-> (tab[chk_idx] >= chk_old));
  // R7
  sel_toward_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_move && !chk_gr) |-> (tab[chk_idx] <= chk_old));
endmodule

// File: rtl/tourn_bpred.sv
module tourn_bpred #(
  parameter int PC_W   = 32,
  parameter int GHW    = 12,
  parameter int LIDX_W = 10,
  parameter int LHW    = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_taken,
  output logic            lk_glob_pred,
  output logic            lk_loc_pred,
  output logic            lk_use_global,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken,
  input  logic            up_glob_pred,
  input  logic            up_loc_pred
);
  logic [GHW-1:0] ghist;

  always_ff @(posedge clk) begin
    if (!rst_n)        ghist <= '0;
    else if (up_valid) ghist <= {ghist[GHW-2:0], up_taken};
  end

  tbp_global_pht #(.HW(GHW)) u_glob (
    .clk(clk), .rst_n(rst_n), .rd_idx(ghist), .rd_taken(lk_glob_pred),
    .wr_en(up_valid), .wr_idx(ghist), .wr_taken(up_taken));

  tbp_local #(.PC_W(PC_W), .IW(LIDX_W), .LW(LHW)) u_loc (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_pred(lk_loc_pred),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken));

  tbp_chooser #(.HW(GHW)) u_sel (
    .clk(clk), .rst_n(rst_n), .rd_idx(ghist), .use_global(lk_use_global),
    .upd(up_valid), .wr_idx(ghist), .glob_pred(up_glob_pred),
    .loc_pred(up_loc_pred), .taken(up_taken));

  assign lk_taken = lk_use_global ? lk_glob_pred : lk_loc_pred;

  // R4
  ghist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |=> $stable(ghist));
  // R4
  ghist_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> (ghist[0] == $past(up_taken)));
  // R2
  final_is_component_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_glob_pred == lk_loc_pred) |-> (lk_taken == lk_glob_pred));
endmodule

// File: tb/sim_tourn_bpred.sv
module sim_tourn_bpred;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] lk_pc, up_pc;
  logic        lk_taken, lk_glob_pred, lk_loc_pred, lk_use_global;
  logic        up_valid, up_taken, up_glob_pred, up_loc_pred;

  int n_chk = 0;
  int n_fail = 0;

  // independent model
  int m_g [4096];
  int m_c [4096];
  int m_l [1024];
  int m_h [1024];
  int m_gh;

  always #(CLK_P/2) clk = ~clk;

  tourn_bpred u0 (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
    .lk_glob_pred(lk_glob_pred), .lk_loc_pred(lk_loc_pred),
    .lk_use_global(lk_use_global), .up_valid(up_valid), .up_pc(up_pc),
    .up_taken(up_taken), .up_glob_pred(up_glob_pred), .up_loc_pred(up_loc_pred));

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 4096; i++) begin m_g[i] = 1; m_c[i] = 1; end
    for (int i = 0; i < 1024; i++) begin m_l[i] = 3; m_h[i] = 0; end
    m_gh = 0;
  endtask

  function automatic int lidx(input logic [31:0] pc);
    return int'((pc >> 2) & 32'h3FF);
  endfunction

  // lookup at pc, compare all outputs against the model
  task automatic look(input logic [31:0] pc, input string req, output int gp, output int lp);
    int ug, fin;
    lk_pc = pc;
    #1;
    gp  = (m_g[m_gh] >= 2) ? 1 : 0;
    lp  = (m_l[m_h[lidx(pc)]] >= 4) ? 1 : 0;
    ug  = (m_c[m_gh] >= 2) ? 1 : 0;
    fin = ug ? gp : lp;
    check(req, "glob_pred", int'(lk_glob_pred), gp);
    check(req, "loc_pred", int'(lk_loc_pred), lp);
    check(req, "use_global", int'(lk_use_global), ug);
    check(req, "taken", int'(lk_taken), fin);
  endtask

  // one branch: lookup, check, then update (R8: update visible only after edge)
  task automatic branch(input logic [31:0] pc, input bit t, input string req);
    int gp, lp, li, hi;
    @(negedge clk);
    look(pc, req, gp, lp);
    up_valid = 1'b1; up_pc = pc; up_taken = t;
    up_glob_pred = gp[0]; up_loc_pred = lp[0];
    @(posedge clk);
    // model update
    li = lidx(pc); hi = m_h[li];
    m_g[m_gh] = t ? ((m_g[m_gh] < 3) ? m_g[m_gh] + 1 : 3) : ((m_g[m_gh] > 0) ? m_g[m_gh] - 1 : 0);
    m_l[hi]   = t ? ((m_l[hi] < 7) ? m_l[hi] + 1 : 7) : ((m_l[hi] > 0) ? m_l[hi] - 1 : 0);
    if (gp != lp) begin
      if (gp == int'(t)) m_c[m_gh] = (m_c[m_gh] < 3) ? m_c[m_gh] + 1 : 3;
      else               m_c[m_gh] = (m_c[m_gh] > 0) ? m_c[m_gh] - 1 : 0;
    end
    m_h[li] = ((hi << 1) | int'(t)) & 1023;
    m_gh    = ((m_gh << 1) | int'(t)) & 4095;
    @(negedge clk);
    up_valid = 1'b0;
  endtask

  task automatic t_reset();
    int gp, lp;
    @(negedge clk);
    look(32'h0000_0400, "R1", gp, lp);
    check("R1", "reset taken", int'(lk_taken), 0);
    check("R1", "reset use_global", int'(lk_use_global), 0);
  endtask

  // R6 / R3 saturation: long taken run then not-taken run on one branch
  task automatic t_saturate();
    for (int i = 0; i < 20; i++) branch(32'h0000_0100, 1'b1, "R6");
    for (int i = 0; i < 20; i++) branch(32'h0000_0100, 1'b0, "R3");
    for (int i = 0; i < 5; i++)  branch(32'h0000_0100, 1'b1, "R6");
  endtask

  // R5: loop branch, taken 4 times then exit, repeated
  task automatic t_loop();
    for (int r = 0; r < 12; r++)
      for (int i = 0; i < 5; i++) branch(32'h0000_2230, (i != 4), "R5");
  endtask

  // R7 / R2: correlated pair, second follows first
  task automatic t_correlated();
    bit prev;
    prev = 1'b0;
    for (int i = 0; i < 80; i++) begin
      prev = ((i * 7) % 3 == 0);
      branch(32'h0000_0840, prev, "R7");
      branch(32'h0000_0A80, prev, "R2");
    end
  endtask

  // R9: PCs differing only outside [11:2] share predictions
  task automatic t_alias();
    int g1, l1, g2, l2;
    for (int i = 0; i < 12; i++) branch(32'h0000_0F0C, 1'b1, "R9");
    @(negedge clk);
    look(32'h0000_0F0C, "R9", g1, l1);
    look(32'hABCD_0F0F, "R9", g2, l2);
    check("R9", "alias loc equal", int'(lk_loc_pred), l1);
    check("R9", "alias taken equal", g2, g1);
  endtask

  // R4 / R8: without updates nothing moves
  task automatic t_hold();
    int g1, l1, g2, l2;
    @(negedge clk);
    look(32'h0000_0F0C, "R4", g1, l1);
    repeat (5) @(posedge clk);
    @(negedge clk);
    look(32'h0000_0F0C, "R8", g2, l2);
    check("R4", "hold glob", g2, g1);
    check("R8", "hold loc", l2, l1);
  endtask

  // mixed stream
  task automatic t_mixed();
    logic [15:0] lf;
    lf = 16'hACE1;
    for (int i = 0; i < 1500; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      branch({20'h0, lf[3:0], 8'h04}, (lf[7] | (i % 3 == 0)), "R2");
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; lk_pc = '0; up_pc = '0; up_valid = 1'b0;
    up_taken = 1'b0; up_glob_pred = 1'b0; up_loc_pred = 1'b0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_saturate();
    t_loop();
    t_correlated();
    t_alias();
    t_hold();
    t_mixed();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule